// File: doc/BRIEF.md
# Push-Button Sine Preset Selector

This controller lets two push buttons choose one of sixteen fixed sine presets for a direct digital synthesizer when no host is attached. The presets form two banks of eight frequencies, and each button owns one bank. Releasing a button after a debounced press steps to the next entry of that button's bank. If the other bank was active, the release switches to that bank and selects its first entry.

The block drives eight LEDs. The LED polarity depends on the active bank. Bank A lights exactly one LED at the selected index. Bank B darkens exactly one LED at the selected index and lights the other seven. The block also outputs the 24-bit phase increment of the selected preset. It produces two timing pulses, one for the DAC sample update and one that paces the DAC serial clock. Both come from the system clock.

Top module: `wave_preset_sel`

## Requirements
- R1: After reset, bank A and index 0 are active, `led_o` is 8'b0000_0001, and `phase_inc_o` holds the bank A index 0 increment.
- R2: A button level must stay stable for DEB_CYC consecutive clocks before the block accepts it. A press shorter than that changes neither `led_o` nor `phase_inc_o`.
- R3: In bank A, a release of button A advances the index by one. `led_o` then has exactly one bit set, at position index (bit 0 = index 0).
- R4: The index wraps from 7 back to 0 on the next release in the same bank.
- R5: In bank B, a release of button B advances the index. `led_o` then has exactly one bit clear, at position index, and all other bits set.
- R6: A release of the button for the inactive bank makes that bank active at index 0.
- R7: `phase_inc_o` equals floor(BASE_HZ × (index+1) × 2^24 / UPDATE_HZ), with BASE_HZ = 1000 for bank A and 125 for bank B.
- R8: `update_stb_o` is a one-cycle pulse every CLK_HZ/UPDATE_HZ clocks (250 with the default 50 MHz and 200 kHz).
- R9: `sclk_en_o` is a one-cycle pulse every CLK_HZ/SCLK_HZ clocks (5 with the default 50 MHz and 10 MHz).
- R10: If both buttons release in the same cycle, button A takes effect and button B is ignored.
- R11: The selection changes on release, not on press. While a button is held, the outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_a_i | input | 1 | Button A, high while pressed (raw) |
| btn_b_i | input | 1 | Button B, high while pressed (raw) |
| led_o | output | 8 | Selection display |
| phase_inc_o | output | 24 | Phase increment of the selected preset |
| update_stb_o | output | 1 | DAC sample update pulse |
| sclk_en_o | output | 1 | Serial clock pacing pulse |

## Verification
Corrupted bank or index state shows on the outputs immediately. `led_o` and `phase_inc_o` are decoded combinationally from the state registers, so a wrong bank bit appears as a wrong LED polarity in the same cycle, and a wrong index appears as a misplaced LED and a wrong increment. A debouncer fault shows up two synchronizer cycles plus DEB_CYC clocks after the button edge: a short glitch advances the selection, or a held press does not. A fault in a rate divider shows as an interval between pulses that differs from the nominal one, visible within two periods.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic logic [23:0] preset_inc(input longint unsigned base_hz,
                                             input int unsigned idx,
                                             input longint unsigned upd_hz);
    longint unsigned num;
    num = (base_hz * longint'(idx + 1)) << 24;
    return 24'(num / upd_hz);
  endfunction
endpackage

// File: rtl/wps_debounce.sv
module wps_debounce #(
  parameter int unsigned DEB_CYC = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rel_o
);
  localparam int unsigned CW = $clog2(DEB_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          stable_q, stable_d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q      <= '0;
      cnt_q       <= '0;
      stable_q    <= 1'b0;
      stable_d1_q <= 1'b0;
    end else begin
      sync_q      <= {sync_q[0], raw_i};
      stable_d1_q <= stable_q;
      if (sync_q[1] == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_CYC - 1)) begin
        stable_q <= sync_q[1];
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rel_o = stable_d1_q & ~stable_q;

  // R2
  stable_follows_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stable_q != $past(stable_q)) |-> ($past(sync_q[1]) == stable_q));
endmodule

// File: rtl/wps_rate_gen.sv
module wps_rate_gen #(
  parameter int unsigned DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == CW'(DIV - 1));
      cnt_q  <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  // R8 R9
  single_cycle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wps_select.sv
module wps_select
  import wps_pkg::*;
#(
  parameter int unsigned NPRE = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rel_a_i,
  input  logic                    rel_b_i,
  output bank_e                   bank_o,
  output logic [$clog2(NPRE)-1:0] idx_o
);
  localparam int unsigned IW = $clog2(NPRE);

  bank_e         bank_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= BANK_A;
      idx_q  <= '0;
    end else if (rel_a_i) begin
      if (bank_q == BANK_A) idx_q <= (idx_q == IW'(NPRE - 1)) ? '0 : idx_q + 1'b1;
      else begin bank_q <= BANK_A; idx_q <= '0; end
    end else if (rel_b_i) begin
      if (bank_q == BANK_B) idx_q <= (idx_q == IW'(NPRE - 1)) ? '0 : idx_q + 1'b1;
      else begin bank_q <= BANK_B; idx_q <= '0; end
    end
  end

  assign bank_o = bank_q;
  assign idx_o  = idx_q;

  // R4
  idx_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_a_i && bank_q == BANK_A && idx_q == IW'(NPRE - 1)) |=> (idx_q == '0));
  // R6
  bank_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_b_i && !rel_a_i && bank_q == BANK_A) |=> (bank_q == BANK_B && idx_q == '0));
  // R10
  a_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_a_i && rel_b_i) |=> (bank_q == BANK_A));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(rel_a_i) && !$past(rel_b_i)) |-> ($stable(idx_q) && $stable(bank_q)));
endmodule

// File: rtl/wave_preset_sel.sv
module wave_preset_sel
  import wps_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned UPDATE_HZ = 200_000,
  parameter int unsigned SCLK_HZ   = 10_000_000,
  parameter int unsigned DEB_CYC   = 250_000,
  parameter int unsigned BASE_A_HZ = 1000,
  parameter int unsigned BASE_B_HZ = 125,
  parameter int unsigned NPRE      = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            btn_a_i,
  input  logic            btn_b_i,
  output logic [NPRE-1:0] led_o,
  output logic [23:0]     phase_inc_o,
  output logic            update_stb_o,
  output logic            sclk_en_o
);
  localparam int unsigned IW       = $clog2(NPRE);
  localparam int unsigned UPD_DIV  = CLK_HZ / UPDATE_HZ;
  localparam int unsigned SCLK_DIV = CLK_HZ / SCLK_HZ;

  logic [1:0]    btn_raw, rel;
  bank_e         bank;
  logic [IW-1:0] idx;
  logic [23:0]   lut_a [NPRE];
  logic [23:0]   lut_b [NPRE];
  logic [NPRE-1:0] one_hot;

  assign btn_raw = {btn_b_i, btn_a_i};

  for (genvar g = 0; g < 2; g++) begin : g_deb
    wps_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (btn_raw[g]),
      .rel_o (rel[g])
    );
  end

  wps_select #(.NPRE(NPRE)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rel_a_i(rel[0]),
    .rel_b_i(rel[1]),
    .bank_o (bank),
    .idx_o  (idx)
  );

  for (genvar i = 0; i < NPRE; i++) begin : g_lut
    assign lut_a[i] = preset_inc(longint'(BASE_A_HZ), i, longint'(UPDATE_HZ));
    assign lut_b[i] = preset_inc(longint'(BASE_B_HZ), i, longint'(UPDATE_HZ));
  end

  assign one_hot     = NPRE'(1) << idx;
  assign led_o       = (bank == BANK_A) ? one_hot : ~one_hot;
  assign phase_inc_o = (bank == BANK_A) ? lut_a[idx] : lut_b[idx];

  wps_rate_gen #(.DIV(UPD_DIV)) u_upd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(update_stb_o)
  );

  wps_rate_gen #(.DIV(SCLK_DIV)) u_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(sclk_en_o)
  );

  // R3
  led_one_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank == BANK_A) |-> $onehot(led_o));
  // R5
  led_one_cold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank == BANK_B) |-> $onehot(~led_o));
endmodule

// File: tb/sim_wave_preset_sel.sv
module sim_wave_preset_sel;
  localparam int DEB = 20;
  localparam int WAIT = 80;

  logic clk = 1'b0, rst_n = 1'b0, btn_a = 1'b0, btn_b = 1'b0;
  logic [7:0]  led;
  logic [23:0] pinc;
  logic upd, sclk;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wave_preset_sel #(.DEB_CYC(DEB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .btn_a_i(btn_a), .btn_b_i(btn_b),
    .led_o(led), .phase_inc_o(pinc), .update_stb_o(upd), .sclk_en_o(sclk)
  );

  function automatic logic [23:0] exp_inc(input int bank, input int idx);
    longint unsigned f;
    f = (bank == 0) ? 64'd1000 : 64'd125;
    return 24'((f * (idx + 1) * 64'd16777216) / 64'd200000);
  endfunction

  function automatic logic [7:0] exp_led(input int bank, input int idx);
    logic [7:0] v;
    v = 8'd0;
    v[idx] = 1'b1;
    return (bank == 0) ? v : ~v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_sel(input string req, input int bank, input int idx);
    chk(req, 32'(led), 32'(exp_led(bank, idx)));
    chk(req, 32'(pinc), 32'(exp_inc(bank, idx)));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic click(input logic a, input logic b);
    @(negedge clk);
    btn_a = a; btn_b = b;
    wait_cyc(WAIT);
    btn_a = 1'b0; btn_b = 1'b0;
    wait_cyc(WAIT);
  endtask

  task automatic t_reset();
    chk_sel("R1", 0, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk); btn_a = 1'b1;
    wait_cyc(DEB / 2);
    btn_a = 1'b0;
    wait_cyc(WAIT);
    chk_sel("R2", 0, 0);
  endtask

  task automatic t_hold_then_release();
    @(negedge clk); btn_a = 1'b1;
    wait_cyc(WAIT);
    chk_sel("R11", 0, 0);
    btn_a = 1'b0;
    wait_cyc(WAIT);
    chk_sel("R3", 0, 1);
  endtask

  task automatic t_walk_wrap();
    for (int i = 2; i < 8; i++) begin
      click(1'b1, 1'b0);
      chk_sel("R3", 0, i);
      chk_sel("R7", 0, i);
    end
    click(1'b1, 1'b0);
    chk_sel("R4", 0, 0);
  endtask

  task automatic t_bank_b();
    click(1'b1, 1'b0);
    click(1'b0, 1'b1);
    chk_sel("R6", 1, 0);
    for (int i = 1; i < 8; i++) begin
      click(1'b0, 1'b1);
      chk_sel("R5", 1, i);
    end
    click(1'b0, 1'b1);
    chk_sel("R4", 1, 0);
    click(1'b0, 1'b1);
    click(1'b0, 1'b1);
    chk_sel("R7", 1, 2);
  endtask

  task automatic t_both();
    click(1'b1, 1'b1);
    chk_sel("R10", 0, 0);
    click(1'b1, 1'b1);
    chk_sel("R10", 0, 1);
  endtask

  task automatic t_period(input string req, input bit which, input int exp);
    int t0 = 0, n = 0, t1 = 0, t2 = 0;
    bit done = 0;
    for (int c = 0; c < 2000 && !done; c++) begin
      @(negedge clk);
      if ((which ? sclk : upd) === 1'b1) begin
        n++;
        if (n == 1) t0 = c;
        if (n == 2) t1 = c;
        if (n == 3) begin t2 = c; done = 1; end
      end
    end
    chk(req, 32'(t1 - t0), 32'(exp));
    chk(req, 32'(t2 - t1), 32'(exp));
  endtask

  initial begin
    fork
      begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_glitch();
        t_hold_then_release();
        t_walk_wrap();
        t_bank_b();
        t_both();
        t_period("R8", 1'b0, 250);
        t_period("R9", 1'b1, 5);
      end
      begin
        wait_cyc(150000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule